// File: doc/BRIEF.md
# Low-Window Paged Address Translator

This unit sits between a minicomputer core and its memory. The core issues 12-bit word addresses with a 3-bit field selector. Any address from 0 to 63 (octal 0 to 77) is translated. Address bits [5:3] select one of eight live table entries, and bits [2:0] are the offset within the page. Every other address goes to memory unchanged, with the field bits prepended. The table is the same for all fields, so data placed in the window stays at the same place across a cross-field call.

A table (a "context") is one 8-word chunk of memory. Word k of that chunk holds the physical chunk number for virtual page k. Word 0 holds the context's own chunk number, so virtual page 0 addresses the table itself. Software can therefore retarget pages 1 to 7 with ordinary stores to addresses 1 to 7. The unit watches for those stores and copies the data into its live entries. A context-enable strobe names a chunk. The unit then fetches the eight words over a dedicated read port and holds the core in stall until all eight have arrived. It swaps the whole table in at once.

Top module: `lowwin_xlat`

## Requirements
- R1: After reset, stall, rd_req and mem_valid are low, and table entry k holds chunk k. A window access then reaches physical address equal to the 6-bit window address, whatever the field.
- R2: An accepted access to an address of 64 or above produces, one cycle later, mem_valid high, mem_addr = {field, address}, and mem_we and mem_wdata equal to the request's values.
- R3: An accepted access to window address a produces, one cycle later, mem_addr = {entry[a[5:3]], a[2:0]}. This is the 12-bit chunk times 8 plus the offset, as a 15-bit address, and the field bits are not used.
- R4: A store to window address 1 to 7 is written to memory through the current mapping. In the same cycle the data is copied into entry a[2:0], so the very next access uses the new chunk.
- R5: A store to window address 0 is written to memory only. Entry 0 is unchanged until the next context load.
- R6: A context-enable with chunk c, accepted while not stalled, raises stall on the next cycle. It then requests words c*8+0 through c*8+7 in ascending order, advancing by one word for each cycle in which rd_req and rd_gnt are both high. Exactly eight reads are granted.
- R7: Stall stays high until the eighth word has returned on rd_valid, and all eight entries are replaced in that same cycle. While stall is high, accesses create no memory transaction and change no entry.
- R8: If a context-enable and a store to window address 1 to 7 arrive in the same cycle, the store still reaches memory through the old mapping. After the load, the table equals the loaded chunk exactly.
- R9: A context-enable presented while stall is high is ignored. The running load keeps its chunk.
- R10: While rd_req is high and rd_gnt is low, rd_req stays high and rd_addr holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Core presents an access this cycle |
| cpu_addr | input | 12 | Word address within the field |
| cpu_field | input | 3 | Field selector |
| cpu_we | input | 1 | Access is a store |
| cpu_wdata | input | 12 | Store data |
| ctx_en | input | 1 | Context-enable strobe |
| ctx_chunk | input | 12 | Chunk number of the context to load |
| stall | output | 1 | Core must hold while a context loads |
| mem_valid | output | 1 | Registered memory access valid |
| mem_we | output | 1 | Registered store flag |
| mem_addr | output | 15 | Registered physical word address |
| mem_wdata | output | 12 | Registered store data |
| rd_req | output | 1 | Context word read request |
| rd_addr | output | 15 | Physical address of requested context word |
| rd_gnt | input | 1 | Memory accepts the read this cycle |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 12 | Returned context word |

## Verification
Two functions can fall in the same cycle: a snooped store into the live table and the start of a context load. The bench provokes this by raising ctx_en in the same cycle as a store to a window address from 1 to 7 that targets a page whose loaded value differs. It checks that the store appears on the memory port under the old mapping. After stall falls, every page is probed to confirm that the table matches the fetched chunk and that the snooped value was not kept. Grants are withheld at random during every load. Random accesses and loads are mixed with these directed cases, so snoops also land right before and after a load.

// File: rtl/lwx_pkg.sv
package lwx_pkg;
  localparam int ADDR_W  = 12;
  localparam int FIELD_W = 3;
  localparam int WORD_W  = 12;
  localparam int OFF_W   = 3;
  localparam int PG_W    = 3;
  localparam int NPAGES  = 1 << PG_W;
  localparam int WIN_W   = OFF_W + PG_W;
  localparam int PA_W    = WORD_W + OFF_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PA_W-1:0]   paddr_t;
endpackage

// File: rtl/lwx_loader.sv
module lwx_loader
  import lwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctx_en,
  input  word_t             ctx_chunk,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  output logic              busy,
  output logic              ctx_go,
  output logic              rd_req,
  output paddr_t            rd_addr,
  output logic              ld_we,
  output logic [PG_W-1:0]   ld_idx,
  output logic              commit
);
  word_t           base_q;
  logic [PG_W:0]   req_cnt;
  logic [PG_W-1:0] rcv_cnt;

  assign ctx_go  = ctx_en && !busy;
  assign rd_req  = busy && !req_cnt[PG_W];
  assign rd_addr = {base_q, req_cnt[PG_W-1:0]};
  assign ld_we   = busy && rd_valid;
  assign ld_idx  = rcv_cnt;
  assign commit  = ld_we && (rcv_cnt == {PG_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      base_q  <= '0;
      req_cnt <= '0;
      rcv_cnt <= '0;
    end else if (ctx_go) begin
      busy    <= 1'b1;
      base_q  <= ctx_chunk;
      req_cnt <= '0;
      rcv_cnt <= '0;
    end else if (busy) begin
      if (rd_req && rd_gnt) req_cnt <= req_cnt + 1'b1;
      if (ld_we)            rcv_cnt <= rcv_cnt + 1'b1;
      if (commit)           busy    <= 1'b0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr)); // R10

  AST_RCV_LE_REQ: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, rcv_cnt} <= req_cnt)); // R6
endmodule

// File: rtl/lwx_table.sv
module lwx_table
  import lwx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          snoop_we,
  input  logic [PG_W-1:0]               snoop_idx,
  input  word_t                         snoop_data,
  input  logic                          ld_we,
  input  logic [PG_W-1:0]               ld_idx,
  input  word_t                         ld_data,
  input  logic                          commit,
  output logic [NPAGES-1:0][WORD_W-1:0] tbl
);
  word_t shadow [NPAGES];

  always_ff @(posedge clk) begin
    if (ld_we) shadow[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAGES; k++) tbl[k] <= WORD_W'(k);
    end else if (commit) begin
      for (int k = 0; k < NPAGES; k++)
        tbl[k] <= (PG_W'(k) == ld_idx) ? ld_data : shadow[k];
    end else if (snoop_we) begin
      tbl[snoop_idx] <= snoop_data;
    end
  end

  AST_ENTRY0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(tbl[0])); // R5

  AST_NO_SNOOP_AT_SWAP: assert property (@(posedge clk) disable iff (rst)
    commit |-> !snoop_we); // R7
endmodule

// File: rtl/lwx_xlat.sv
module lwx_xlat
  import lwx_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_valid,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [FIELD_W-1:0]            cpu_field,
  input  logic                          cpu_we,
  input  word_t                         cpu_wdata,
  input  logic                          stall,
  input  logic [NPAGES-1:0][WORD_W-1:0] tbl,
  output logic                          snoop_hit,
  output logic [PG_W-1:0]               snoop_idx,
  output logic                          mem_valid,
  output logic                          mem_we,
  output paddr_t                        mem_addr,
  output word_t                         mem_wdata
);
  logic            in_win, accept;
  logic [PG_W-1:0] pg;
  logic [OFF_W-1:0] off;
  paddr_t          phys;

  assign pg     = cpu_addr[WIN_W-1:OFF_W];
  assign off    = cpu_addr[OFF_W-1:0];
  assign in_win = (cpu_addr[ADDR_W-1:WIN_W] == '0);
  assign accept = cpu_valid && !stall;

  always_comb begin
    if (in_win) phys = {tbl[pg], off};
    else        phys = {cpu_field, cpu_addr};
  end

  assign snoop_hit = accept && cpu_we && in_win && (pg == '0) && (off != '0);
  assign snoop_idx = off;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_valid <= accept;
      mem_we    <= accept && cpu_we;
      mem_addr  <= phys;
      mem_wdata <= cpu_wdata;
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && !stall && (cpu_addr[ADDR_W-1:WIN_W] != '0)
    |=> mem_valid && (mem_addr == {$past(cpu_field), $past(cpu_addr)})); // R2

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> !mem_valid); // R7
endmodule

// File: rtl/lowwin_xlat.sv
module lowwin_xlat
  import lwx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_valid,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [FIELD_W-1:0] cpu_field,
  input  logic               cpu_we,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic               ctx_en,
  input  logic [WORD_W-1:0]  ctx_chunk,
  output logic               stall,
  output logic               mem_valid,
  output logic               mem_we,
  output logic [PA_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               rd_req,
  output logic [PA_W-1:0]    rd_addr,
  input  logic               rd_gnt,
  input  logic               rd_valid,
  input  logic [WORD_W-1:0]  rd_data
);
  logic                          ctx_go, ld_we, commit, snoop_hit, snoop_we;
  logic [PG_W-1:0]               ld_idx, snoop_idx;
  logic [NPAGES-1:0][WORD_W-1:0] tbl;

  lwx_loader u_loader (
    .clk      (clk),
    .rst      (rst),
    .ctx_en   (ctx_en),
    .ctx_chunk(ctx_chunk),
    .rd_gnt   (rd_gnt),
    .rd_valid (rd_valid),
    .busy     (stall),
    .ctx_go   (ctx_go),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .ld_we    (ld_we),
    .ld_idx   (ld_idx),
    .commit   (commit)
  );

  // A load starting this cycle replaces the whole table, so the snoop is dropped.
  assign snoop_we = snoop_hit && !ctx_go;

  lwx_table u_table (
    .clk       (clk),
    .rst       (rst),
    .snoop_we  (snoop_we),
    .snoop_idx (snoop_idx),
    .snoop_data(cpu_wdata),
    .ld_we     (ld_we),
    .ld_idx    (ld_idx),
    .ld_data   (rd_data),
    .commit    (commit),
    .tbl       (tbl)
  );

  lwx_xlat u_xlat (
    .clk      (clk),
    .rst      (rst),
    .cpu_valid(cpu_valid),
    .cpu_addr (cpu_addr),
    .cpu_field(cpu_field),
    .cpu_we   (cpu_we),
    .cpu_wdata(cpu_wdata),
    .stall    (stall),
    .tbl      (tbl),
    .snoop_hit(snoop_hit),
    .snoop_idx(snoop_idx),
    .mem_valid(mem_valid),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  AST_LOAD_STALLS: assert property (@(posedge clk) disable iff (rst)
    ctx_en && !stall |=> stall); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall && !(rd_valid && $fell(rd_req)) && !rd_valid |=> stall); // R7
endmodule

// File: tb/tb_lowwin_xlat.sv
`timescale 1ns/1ps
module tb_lowwin_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0, cpu_wdata = '0;
  logic [2:0]  cpu_field = '0;
  logic        ctx_en = 1'b0;
  logic [11:0] ctx_chunk = '0;
  logic        stall, mem_valid, mem_we, rd_req;
  logic [14:0] mem_addr, rd_addr;
  logic [11:0] mem_wdata;
  logic        rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [11:0] rd_data = '0;

  logic [11:0] mem [32768];
  logic [11:0] m_tbl [8];
  logic [11:0] exp_base = '0;
  int          rd_idx = 0;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  lowwin_xlat dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_field(cpu_field), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .ctx_en(ctx_en), .ctx_chunk(ctx_chunk), .stall(stall),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] xl(input logic [11:0] a, input logic [2:0] f);
    if (a[11:6] == 6'd0) return {m_tbl[a[5:3]], a[2:0]};
    return {f, a};
  endfunction

  // memory model: writes, context reads, random grants
  always @(posedge clk) begin
    if (mem_valid && mem_we) mem[mem_addr] <= mem_wdata;
    rd_valid <= rd_req && rd_gnt;
    rd_data  <= mem[rd_addr];
    if (rd_req && rd_gnt) begin
      chk("R6 context read address", 32'(rd_addr), 32'({exp_base, 3'(rd_idx)}));
      rd_idx++;
    end
  end
  always @(negedge clk) rd_gnt <= ($urandom % 4) != 0;

  task automatic access(input string req, input logic [11:0] a, input logic [2:0] f,
                        input logic we, input logic [11:0] d);
    logic [14:0] e;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_field = f; cpu_we = we; cpu_wdata = d;
    e = xl(a, f);
    @(negedge clk);
    chk({req, " valid"}, 32'(mem_valid), 1);
    chk({req, " addr"}, 32'(mem_addr), 32'(e));
    chk({req, " we"}, 32'(mem_we), 32'(we));
    if (we) chk({req, " wdata"}, 32'(mem_wdata), 32'(d));
    if (we && a[11:3] == 9'd0 && a[2:0] != 3'd0) m_tbl[a[2:0]] = d;
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic prep_ctx(input logic [11:0] c);
    mem[{c, 3'd0}] = c;
    for (int k = 1; k < 8; k++) mem[{c, 3'(k)}] = 12'($urandom);
  endtask

  task automatic load_ctx(input logic [11:0] c, input logic clash,
                          input logic [2:0] cidx, input logic [11:0] cval);
    logic [14:0] e;
    int n;
    @(negedge clk);
    ctx_en = 1'b1; ctx_chunk = c; exp_base = c; rd_idx = 0;
    if (clash) begin
      cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = {9'd0, cidx}; cpu_wdata = cval;
      cpu_field = 3'd0;
    end
    e = xl({9'd0, cidx}, 3'd0);
    @(negedge clk);
    chk("R6 stall rises", 32'(stall), 1);
    if (clash) begin
      chk("R8 clash store valid", 32'(mem_valid && mem_we), 1);
      chk("R8 clash store old mapping", 32'(mem_addr), 32'(e));
      chk("R8 clash store data", 32'(mem_wdata), 32'(cval));
    end
    ctx_en = 1'b0;
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 12'd6; cpu_wdata = 12'habc;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      chk("R7 no access while stalled", 32'(mem_valid), 0);
      ctx_en = (n == 1) && stall;
      ctx_chunk = c ^ 12'h001;
    end while (stall && n < 300);
    ctx_en = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0;
    chk("R7 stall falls", 32'(stall), 0);
    chk("R6 eight reads granted (R9 second enable ignored)", 32'(rd_idx), 8);
    chk("R6 no further request", 32'(rd_req), 0);
    for (int k = 0; k < 8; k++) m_tbl[k] = mem[{c, 3'(k)}];
  endtask

  task automatic probe_all(input string req);
    for (int k = 0; k < 8; k++)
      access(req, 12'((k * 8) + ($urandom % 8)), 3'($urandom), 1'b0, 12'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32768; i++) mem[i] = 12'(i * 7);
    for (int k = 0; k < 8; k++) m_tbl[k] = 12'(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 stall after reset", 32'(stall), 0);
    chk("R1 rd_req after reset", 32'(rd_req), 0);
    chk("R1 mem_valid after reset", 32'(mem_valid), 0);
    access("R1 identity window", 12'o45, 3'd5, 1'b0, 12'd0);
    chk("R1 identity value", 32'(xl(12'o45, 3'd5)), 32'o45);
    access("R2 pass read", 12'o100, 3'd7, 1'b0, 12'd0);
    access("R2 pass store", 12'o7777, 3'd2, 1'b1, 12'h5a5);
    access("R4 snoop store", 12'd5, 3'd1, 1'b1, 12'h123);
    access("R4 new mapping used", 12'o52, 3'd0, 1'b0, 12'd0);
    chk("R4 mapped value", 32'(xl(12'o52, 3'd0)), 32'({12'h123, 3'd2}));
    access("R5 store to word 0", 12'd0, 3'd3, 1'b1, 12'h777);
    access("R5 entry 0 unchanged", 12'd3, 3'd0, 1'b0, 12'd0);
    chk("R5 mapped value", 32'(xl(12'd3, 3'd0)), 32'd3);
    access("R3 window page 7", 12'o77, 3'd4, 1'b0, 12'd0);
    prep_ctx(12'h050);
    load_ctx(12'h050, 1'b0, 3'd0, 12'd0);
    probe_all("R7 new table");
    prep_ctx(12'h3a1);
    load_ctx(12'h3a1, 1'b1, 3'd2, 12'hfff);
    probe_all("R8 table equals loaded chunk");
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) begin
        logic [11:0] c;
        c = 12'($urandom);
        prep_ctx(c);
        load_ctx(c, r == 0, 3'(1 + $urandom % 7), 12'($urandom));
      end else if (r < 55) begin
        access("R3 random window", 12'($urandom % 64), 3'($urandom),
               1'($urandom), 12'($urandom));
      end else begin
        access("R2 random pass", 12'(64 + $urandom % 4032), 3'($urandom),
               1'($urandom), 12'($urandom));
      end
    end
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule